// File: doc/BRIEF.md
# Load-Power-Graded Switch Segment Selector

This block sizes the power switches of a buck converter to match the load. An external hysteretic comparator produces a pulse stream whose toggle rate grows with the inductor current. The block counts the rising edges of that stream, but only while the high-side switch is commanded on, over a window of fast-clock cycles. At the end of each window it multiplies the count by the 8-bit output-voltage code, which gives a figure proportional to output power. It then grades that figure against seven thresholds into a 3-bit level.

The level is turned into a thermometer set of segment enables. The same set drives both the low-side NMOS array and the high-side PMOS array. A heavy load turns on many parallel segments, which lowers conduction loss. A light load keeps only the first segment, which lowers switching loss. A new level waits until a dead time, when both gate commands are off, so that no segment changes in the middle of a conduction pulse. Each segment gate output is its enable combined with the matching gate command, and it is registered.

Top module: `load_seg_selector`

## Requirements
- R1: The comparator input passes through a two-stage synchronizer. A rising edge of the synchronized signal adds one to the current count only in a cycle where `hs_cmd` is high. Edges seen while `hs_cmd` is low are not counted.
- R2: A measurement window lasts `win_len` clock cycles, and a value of 0 acts as 1. At the last cycle of each window the count, including any edge in that cycle, is handed to the grader, and the count restarts from zero for the next window.
- R3: The current count is 8 bits wide and holds at 255 instead of wrapping.
- R4: The product is count × `vout_code` as a 16-bit unsigned value. The new level equals the number of the seven 16-bit thresholds that the product strictly exceeds. Threshold i occupies bits [16*i+15:16*i] of `thr_vec`.
- R5: The level in effect (`lvl_out`) changes only on a clock edge where both `hs_cmd` and `ls_cmd` are low. A newer level that arrives while one command is high stays pending, and the most recent pending value is the one applied. After reset the level is 0 and all gate outputs are 0.
- R6: Segments form a thermometer code, where segment k is enabled for k < n. n is 1 for level 0, level+1 for levels 1 to 6, and 7 for level 7.
- R7: `ls_seg_gate[k]` and `hs_seg_gate[k]` are registered copies of enable k ANDed with `ls_cmd` and `hs_cmd` respectively. They appear one clock after the command, and both arrays use the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_pulse | input | 1 | Asynchronous comparator output; its toggle rate tracks inductor current |
| vout_code | input | 8 | Output-voltage code |
| hs_cmd | input | 1 | High-side gate command |
| ls_cmd | input | 1 | Low-side gate command |
| win_len | input | 16 | Measurement window length in clock cycles |
| thr_vec | input | 112 | Seven 16-bit grading thresholds, threshold i at bits 16*i+15:16*i |
| lvl_out | output | 3 | Load level in effect |
| hs_seg_gate | output | 7 | High-side PMOS segment gate outputs |
| ls_seg_gate | output | 7 | Low-side NMOS segment gate outputs |

## Verification
The bench runs a long window at full pulse rate, long enough that the raw count reaches 500. A wrapping counter would report level 0 there instead of 7. It also holds the high-side command on for thousands of cycles, which leaves no dead time. During that stretch a newer, lower level must stay pending, and a design that switched segments mid-pulse would show `lvl_out` moving early. Further cases cover a zero window length, pulses that arrive while the high-side switch is off (a design that ignored the gating would grade them as load), and products sitting exactly on a threshold, where a non-strict compare lands one level high. Segment counts at levels 0, 6 and 7 are compared every cycle, which catches a decoder that omits the one-segment floor or the cap at seven.

// File: rtl/lgs_pkg.sv
package lgs_pkg;
  localparam int LVL_W  = 3;
  localparam int NSEG   = (1 << LVL_W) - 1;
  localparam int NTHR   = NSEG;
  localparam int CNT_W  = 8;
  localparam int VC_W   = 8;
  localparam int PROD_W = CNT_W + VC_W;
  localparam int WIN_W  = 16;

  // number of enabled segments for a level: floor of one, cap at NSEG
  function automatic int seg_count(input logic [LVL_W-1:0] lvl);
    int n;
    n = int'(lvl) + 1;
    if (lvl == '0) n = 1;
    if (n > NSEG) n = NSEG;
    return n;
  endfunction

  function automatic logic [NSEG-1:0] therm_mask(input logic [LVL_W-1:0] lvl);
    logic [NSEG-1:0] m;
    int n;
    n = seg_count(lvl);
    for (int k = 0; k < NSEG; k++) m[k] = (k < n);
    return m;
  endfunction
endpackage

// File: rtl/pulse_window_counter.sv
module pulse_window_counter #(
  parameter int CNT_W = 8,
  parameter int WIN_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  input  logic             hs_cmd,
  input  logic [WIN_W-1:0] win_len,
  output logic [CNT_W-1:0] cnt_done,
  output logic             done_stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // synchronizer chain plus one extra stage for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic [WIN_W-1:0]     wcnt;
  logic [CNT_W-1:0]     cnt;
  logic                 rise;
  logic                 inc;
  logic [CNT_W-1:0]     cnt_nx;
  logic [WIN_W:0]       wnext;
  logic                 term;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], cmp_in};
  end

  assign rise   = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign inc    = rise & hs_cmd;
  assign cnt_nx = (inc && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
  assign wnext  = {1'b0, wcnt} + {{WIN_W{1'b0}}, 1'b1};
  assign term   = (wnext >= {1'b0, win_len});

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt     <= '0;
      cnt      <= '0;
      cnt_done <= '0;
      done_stb <= 1'b0;
    end else if (term) begin
      wcnt     <= '0;
      cnt      <= '0;
      cnt_done <= cnt_nx;
      done_stb <= 1'b1;
    end else begin
      wcnt     <= wcnt + 1'b1;
      cnt      <= cnt_nx;
      done_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/power_grader.sv
module power_grader #(
  parameter int CNT_W = 8,
  parameter int VC_W  = 8,
  parameter int NTHR  = 7,
  parameter int LVL_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          done_stb,
  input  logic [CNT_W-1:0]              cnt_done,
  input  logic [VC_W-1:0]               vout_code,
  input  logic [NTHR*(CNT_W+VC_W)-1:0]  thr_vec,
  output logic [LVL_W-1:0]              lvl_new,
  output logic                          lvl_stb
);
  localparam int PROD_W = CNT_W + VC_W;

  logic [PROD_W-1:0] prod_q;
  logic              prod_vld;
  logic [NTHR-1:0]   above;
  logic [LVL_W-1:0]  lvl_sum;

  // stage 1: power estimate
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q   <= '0;
      prod_vld <= 1'b0;
    end else begin
      prod_vld <= done_stb;
      if (done_stb) prod_q <= PROD_W'(cnt_done) * PROD_W'(vout_code);
    end
  end

  // stage 2: one comparator per threshold
  for (genvar i = 0; i < NTHR; i++) begin : g_cmp
    assign above[i] = prod_q > thr_vec[i*PROD_W +: PROD_W];
  end

  always_comb begin
    lvl_sum = '0;
    for (int i = 0; i < NTHR; i++) lvl_sum = lvl_sum + LVL_W'(above[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_new <= '0;
      lvl_stb <= 1'b0;
    end else begin
      lvl_stb <= prod_vld;
      if (prod_vld) lvl_new <= lvl_sum;
    end
  end
endmodule

// File: rtl/segment_driver.sv
module segment_driver
  import lgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_new,
  input  logic             lvl_stb,
  input  logic             hs_cmd,
  input  logic             ls_cmd,
  output logic [LVL_W-1:0] lvl_cur,
  output logic [NSEG-1:0]  hs_seg,
  output logic [NSEG-1:0]  ls_seg
);
  logic [LVL_W-1:0] pend_lvl;
  logic             pend;
  logic             dead;
  logic             apply;
  logic [LVL_W-1:0] lvl_nx;
  logic [NSEG-1:0]  en_nx;

  assign dead   = ~hs_cmd & ~ls_cmd;
  assign apply  = pend & dead;
  assign lvl_nx = apply ? pend_lvl : lvl_cur;
  assign en_nx  = therm_mask(lvl_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_lvl <= '0;
      pend     <= 1'b0;
      lvl_cur  <= '0;
    end else begin
      lvl_cur <= lvl_nx;
      if (lvl_stb) begin
        pend_lvl <= lvl_new;
        pend     <= 1'b1;
      end else if (apply) begin
        pend     <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        hs_seg[k] <= 1'b0;
        ls_seg[k] <= 1'b0;
      end else begin
        hs_seg[k] <= en_nx[k] & hs_cmd;
        ls_seg[k] <= en_nx[k] & ls_cmd;
      end
    end
  end
endmodule

// File: rtl/load_seg_selector.sv
module load_seg_selector
  import lgs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmp_pulse,
  input  logic [VC_W-1:0]        vout_code,
  input  logic                   hs_cmd,
  input  logic                   ls_cmd,
  input  logic [WIN_W-1:0]       win_len,
  input  logic [NTHR*PROD_W-1:0] thr_vec,
  output logic [LVL_W-1:0]       lvl_out,
  output logic [NSEG-1:0]        hs_seg_gate,
  output logic [NSEG-1:0]        ls_seg_gate
);
  logic [CNT_W-1:0] cnt_done;
  logic             done_stb;
  logic [LVL_W-1:0] lvl_new;
  logic             lvl_stb;

  pulse_window_counter #(
    .CNT_W(CNT_W), .WIN_W(WIN_W), .SYNC_STAGES(2)
  ) u_cnt (
    .clk(clk), .rst(rst), .cmp_in(cmp_pulse), .hs_cmd(hs_cmd),
    .win_len(win_len), .cnt_done(cnt_done), .done_stb(done_stb)
  );

  power_grader #(
    .CNT_W(CNT_W), .VC_W(VC_W), .NTHR(NTHR), .LVL_W(LVL_W)
  ) u_grade (
    .clk(clk), .rst(rst), .done_stb(done_stb), .cnt_done(cnt_done),
    .vout_code(vout_code), .thr_vec(thr_vec),
    .lvl_new(lvl_new), .lvl_stb(lvl_stb)
  );

  segment_driver u_drv (
    .clk(clk), .rst(rst), .lvl_new(lvl_new), .lvl_stb(lvl_stb),
    .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .lvl_cur(lvl_out),
    .hs_seg(hs_seg_gate), .ls_seg(ls_seg_gate)
  );
endmodule

// File: rtl/load_seg_selector_chk.sv
module load_seg_selector_chk
  import lgs_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             hs_cmd,
  input logic             ls_cmd,
  input logic [LVL_W-1:0] lvl_out,
  input logic [NSEG-1:0]  hs_seg_gate,
  input logic [NSEG-1:0]  ls_seg_gate
);
  // R5
  lvl_dead_time_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_out) |-> $past(!hs_cmd && !ls_cmd));

  // R7
  hs_off_chk: assert property (@(posedge clk) disable iff (rst)
    !hs_cmd |=> hs_seg_gate == '0);

  // R7
  ls_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ls_cmd |=> ls_seg_gate == '0);

  // R6
  hs_count_chk: assert property (@(posedge clk) disable iff (rst)
    hs_cmd |=> $countones(hs_seg_gate) == seg_count(lvl_out));

  // R6
  ls_count_chk: assert property (@(posedge clk) disable iff (rst)
    ls_cmd |=> $countones(ls_seg_gate) == seg_count(lvl_out));

  // R6
  therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ((hs_seg_gate + 1'b1) & hs_seg_gate) == '0);
endmodule

bind load_seg_selector load_seg_selector_chk u_chk (
  .clk(clk), .rst(rst), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
  .lvl_out(lvl_out), .hs_seg_gate(hs_seg_gate), .ls_seg_gate(ls_seg_gate)
);

// File: tb/load_seg_selector_test.sv
module load_seg_selector_test;
  localparam time CLK_PER = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmp_pulse = 1'b0;
  logic [7:0]   vout_code = 8'd0;
  logic         hs_cmd = 1'b0;
  logic         ls_cmd = 1'b0;
  logic [15:0]  win_len = 16'd200;
  logic [111:0] thr_vec = '0;
  logic [2:0]   lvl_out;
  logic [6:0]   hs_seg_gate;
  logic [6:0]   ls_seg_gate;

  load_seg_selector uut (
    .clk(clk), .rst(rst), .cmp_pulse(cmp_pulse), .vout_code(vout_code),
    .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .win_len(win_len), .thr_vec(thr_vec),
    .lvl_out(lvl_out), .hs_seg_gate(hs_seg_gate), .ls_seg_gate(ls_seg_gate)
  );

  always #(CLK_PER/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;
  bit cmp_on = 0;

  // stimulus knobs
  int gate_mode = 0;   // 0 both off, 1 alternating with dead time, 2 high side stuck on
  int half = 0;        // comparator toggles every 'half' cycles, 0 = idle
  int phase = 0;
  int tog = 0;
  int cyc = 0;

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [111:0] mk_thr(input int base, input int step);
    logic [111:0] v;
    for (int i = 0; i < 7; i++) v[i*16 +: 16] = 16'(base + step*i);
    return v;
  endfunction

  // stimulus generator and watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    phase = (phase + 1) % 20;
    case (gate_mode)
      1:       begin hs_cmd <= (phase < 10); ls_cmd <= (phase >= 11 && phase < 19); end
      2:       begin hs_cmd <= 1'b1; ls_cmd <= 1'b0; end
      default: begin hs_cmd <= 1'b0; ls_cmd <= 1'b0; end
    endcase
    if (half > 0) begin
      tog++;
      if (tog >= half) begin tog = 0; cmp_pulse <= ~cmp_pulse; end
    end
  end

  // behavioural reference, stepped on each rising edge
  int m_s1, m_s2, m_s3, m_w, m_cnt, m_cntdone, m_done;
  int m_prod, m_prodvld, m_newlvl, m_lvlvld, m_pend, m_pendlvl, m_lvl;
  int m_hs, m_ls;

  function automatic int segs_of(input int lvl);
    int n;
    n = (lvl == 0) ? 1 : ((lvl + 1 > 7) ? 7 : lvl + 1);
    return (1 << n) - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_w = 0; m_cnt = 0; m_cntdone = 0; m_done = 0;
      m_prod = 0; m_prodvld = 0; m_newlvl = 0; m_lvlvld = 0;
      m_pend = 0; m_pendlvl = 0; m_lvl = 0; m_hs = 0; m_ls = 0;
    end else begin
      int nl, ed, nxt, wl;
      bit applied;
      // output stage
      applied = (m_pend != 0) && !hs_cmd && !ls_cmd;
      nl = applied ? m_pendlvl : m_lvl;
      m_hs = hs_cmd ? segs_of(nl) : 0;
      m_ls = ls_cmd ? segs_of(nl) : 0;
      if (m_lvlvld != 0) begin m_pendlvl = m_newlvl; m_pend = 1; end
      else if (applied) m_pend = 0;
      m_lvl = nl;
      // grading
      m_lvlvld = m_prodvld;
      if (m_prodvld != 0) begin
        m_newlvl = 0;
        for (int i = 0; i < 7; i++) if (m_prod > int'(thr_vec[i*16 +: 16])) m_newlvl++;
      end
      // product
      m_prodvld = m_done;
      if (m_done != 0) m_prod = m_cntdone * int'(vout_code);
      // window counting
      ed = (m_s2 == 1 && m_s3 == 0 && hs_cmd) ? 1 : 0;
      nxt = m_cnt + ed;
      if (nxt > 255) nxt = 255;
      wl = (win_len == 0) ? 1 : int'(win_len);
      if (m_w + 1 >= wl) begin
        m_cntdone = nxt; m_done = 1; m_cnt = 0; m_w = 0;
      end else begin
        m_done = 0; m_cnt = nxt; m_w++;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(cmp_pulse);
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && !done_flag) begin
      chk("R5 lvl_out vs model", int'(lvl_out), m_lvl);
      chk("R7 hs_seg_gate vs model", int'(hs_seg_gate), m_hs);
      chk("R7 ls_seg_gate vs model", int'(ls_seg_gate), m_ls);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sample segment outputs while the high-side command has been on for a while
  task automatic check_hs_segs(input string tag, input int exp);
    while (!(hs_cmd && phase == 5)) @(negedge clk);
    @(negedge clk);
    chk(tag, int'(hs_seg_gate), exp);
  endtask

  initial begin
    thr_vec = mk_thr(100, 100);
    wait_cyc(4);
    cmp_on = 1;
    rst = 1'b0;
    chk("R5 reset level", int'(lvl_out), 0);
    chk("R5 reset hs gates", int'(hs_seg_gate), 0);
    chk("R5 reset ls gates", int'(ls_seg_gate), 0);

    // R1: pulses with high side off are not counted
    vout_code = 8'd200; half = 1; gate_mode = 0; thr_vec = mk_thr(0, 0);
    wait_cyc(800);
    chk("R1 ungated pulses ignored", int'(lvl_out), 0);

    // R2/R4: 50 edges per 200-cycle window, x10 = 500 -> level 4
    thr_vec = mk_thr(100, 100); vout_code = 8'd10; gate_mode = 1; win_len = 16'd200;
    wait_cyc(1200);
    chk("R4 product 500 grades to 4", int'(lvl_out), 4);
    check_hs_segs("R6 five segments at level 4", 7'h1f);

    // R2: window 100 -> 25 edges x10 = 250 -> level 2
    win_len = 16'd100;
    wait_cyc(800);
    chk("R2 shorter window level 2", int'(lvl_out), 2);

    // R4 boundary: product 500 equal to threshold 500 is not exceeded
    win_len = 16'd200; thr_vec = mk_thr(200, 100);
    wait_cyc(1200);
    chk("R4 equal product not above", int'(lvl_out), 3);

    // R6: level 7 -> 7 segments
    thr_vec = mk_thr(100, 100); vout_code = 8'd20;
    wait_cyc(1200);
    chk("R6 level 7", int'(lvl_out), 7);
    check_hs_segs("R6 seven segments at level 7", 7'h7f);

    // R6: level 6 capped at seven segments
    thr_vec = mk_thr(100, 100); thr_vec[6*16 +: 16] = 16'd5000;
    wait_cyc(1200);
    chk("R6 level 6", int'(lvl_out), 6);
    check_hs_segs("R6 level 6 gives seven segments", 7'h7f);

    // level 0 -> one segment
    vout_code = 8'd1;
    wait_cyc(1200);
    chk("R6 level 0", int'(lvl_out), 0);
    check_hs_segs("R6 one segment at level 0", 7'h01);

    // R3: 500 raw edges saturate at 255; 255*255 = 65025 > 65000+i
    win_len = 16'd2000; vout_code = 8'd255; thr_vec = mk_thr(65000, 1);
    wait_cyc(7000);
    chk("R3 saturated count grades to 7", int'(lvl_out), 7);

    // R5: high side stuck on, lower level stays pending
    vout_code = 8'd1; win_len = 16'd300; gate_mode = 2;
    wait_cyc(3000);
    chk("R5 level held without dead time", int'(lvl_out), 7);
    chk("R7 low side idle while stuck", int'(ls_seg_gate), 0);
    gate_mode = 0;
    wait_cyc(20);
    chk("R5 pending level applied in dead time", int'(lvl_out), 0);

    // R2: zero window length, count of 0 or 1 per cycle
    gate_mode = 1; win_len = 16'd0; vout_code = 8'd5; thr_vec = mk_thr(4, 0);
    wait_cyc(600);
    half = 2;
    wait_cyc(600);
    half = 3; win_len = 16'd37; vout_code = 8'd40; thr_vec = mk_thr(50, 60);
    wait_cyc(2000);

    // reset mid-run
    rst = 1'b1;
    wait_cyc(2);
    chk("R5 reset mid-run level", int'(lvl_out), 0);
    chk("R5 reset mid-run gates", int'(hs_seg_gate) | int'(ls_seg_gate), 0);
    rst = 1'b0;
    wait_cyc(500);

    finish_run();
  end
endmodule